// File: doc/BRIEF.md
# Dual-Mode Dual-Clock FIFO

This block is a first-in first-out buffer whose write side and read side run on unrelated clocks. Data is 9 bits wide and the storage array depth is a power-of-two parameter. The write pointer and the read pointer cross between the two clock domains as Gray code through multi-flop synchronizers. Every status flag is computed from a local pointer and the synchronized copy of the remote pointer. As a result, a flag may report full or empty for a few cycles longer than the true state, but it never reports free space or data that is not there.

A mode pin is sampled while master reset is held, and the choice lasts until the next master reset. In standard mode, `wr_flag` is an active-low full flag and `rd_flag` is an active-low empty flag. Each word leaves the array only when the reader asks for it with `rd_en`. In first-word-fall-through mode, `wr_flag` is an active-low input-ready flag and `rd_flag` is an active-low output-ready flag. The output register is filled from the array without a request, and it counts as one extra word of capacity.

Two resets are provided. Master reset clears the pointers and flags and also captures the mode. Partial reset clears the pointers and flags but leaves the mode unchanged.

Top module: `twin_mode_fifo`

## Requirements
- R1: In standard mode, after master reset and DEPTH accepted writes with no read, `wr_flag` reads 0 (full). After DEPTH-1 such writes it still reads 1.
- R2: In fall-through mode, once the first word has reached `dout`, `wr_flag` stays 0 (ready) through DEPTH writes in total. It reads 1 after the (DEPTH+1)-th write.
- R3: A write while the full indication is active does not store the word. A read while the empty indication is active leaves `dout` and the contents unchanged. Both rules hold in both modes.
- R4: In standard mode, no word appears on `dout` without a read request, including the first word written into an empty FIFO. A read with `rd_flag`=1 loads the oldest word into `dout` at that `rd_clk` edge.
- R5: In fall-through mode, the first word written into an empty FIFO appears on `dout` at the third rising `rd_clk` edge after the writing `wr_clk` edge. `rd_flag` falls to 0 at that same edge and is still 1 after the second edge.
- R6: In fall-through mode, `rd_flag` returns to 1 only at an `rd_clk` edge with `rd_en`=1 that consumes the last word. `dout` then keeps that last word.
- R7: While `rd_en` is 0, `dout` keeps its value.
- R8: While master reset is low and after it is released, `dout` is 0. In standard mode the flags are `wr_flag`=1 and `rd_flag`=0. In fall-through mode (`fwft_sel`=1 during master reset) they are `wr_flag`=0 and `rd_flag`=1.
- R9: Partial reset empties the FIFO and returns the flags to their reset values. It keeps the mode captured at master reset, whatever `fwft_sel` is during the partial reset.
- R10: Under any mix of writes and reads on the two clocks, words leave in the order they were accepted, with no loss and no duplication. Each pointer crossing the clock domains changes at most one bit per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock |
| rd_clk | input | 1 | Read clock |
| mrst_n | input | 1 | Master reset, active low, asynchronous assertion; the mode is captured while it is low |
| prst_n | input | 1 | Partial reset, active low; clears pointers and flags, keeps the mode |
| fwft_sel | input | 1 | Mode select sampled during master reset: 0 standard, 1 fall-through |
| wr_en | input | 1 | Write request, active high, sampled on `wr_clk` |
| din | input | DW | Write data |
| rd_en | input | 1 | Read request, active high, sampled on `rd_clk` |
| dout | output | DW | Output register |
| wr_flag | output | 1 | Standard mode: 0 means full. Fall-through mode: 0 means space available |
| rd_flag | output | 1 | Standard mode: 0 means empty. Fall-through mode: 0 means `dout` holds a valid word |

## Verification
The hardest state to reach from the ports is the fall-through capacity boundary. The count of DEPTH+1 is only visible once the first word has already moved into the output register, and that move happens on the read clock a few edges after the write. The directed part of the bench therefore writes a single word, counts read edges to catch the third-edge arrival, and only then fills the array and probes the flag on both sides of the boundary. The random part uses two clock periods whose edges never coincide, so the synchronizer latency shifts from operation to operation and the flags are often sampled while they are still pessimistic.

// File: rtl/tmf_pkg.sv
package tmf_pkg;
  typedef enum logic {
    MODE_STD  = 1'b0,
    MODE_FWFT = 1'b1
  } fifo_mode_e;
endpackage

// File: rtl/tmf_sync.sv
module tmf_sync #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stg[0] <= '0;
          else        stg[0] <= d;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stg[s] <= '0;
          else        stg[s] <= stg[s-1];
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/tmf_wr_ctrl.sv
module tmf_wr_ctrl
  import tmf_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        mrst_n,
  input  logic        mode_pin,
  input  logic        wr_en,
  input  logic [AW:0] rgray_sync,
  output logic [AW:0] wgray,
  output logic [AW-1:0] waddr,
  output logic        push,
  output logic        wr_flag
);
  fifo_mode_e  mode_q;
  logic [AW:0] wbin, wbin_nx, wgray_nx;
  logic        full_q;

  function automatic logic [AW:0] to_gray(input logic [AW:0] b);
    return b ^ (b >> 1);
  endfunction

  // full when write pointer is one lap ahead: top two Gray bits inverted
  function automatic logic laps_apart(input logic [AW:0] wg, input logic [AW:0] rg);
    return wg == {~rg[AW:AW-1], rg[AW-2:0]};
  endfunction

  always_ff @(posedge clk)
    if (!mrst_n) mode_q <= fifo_mode_e'(mode_pin);

  assign push     = wr_en & ~full_q;
  assign wbin_nx  = wbin + {{AW{1'b0}}, push};
  assign wgray_nx = to_gray(wbin_nx);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wbin   <= '0;
      wgray  <= '0;
      full_q <= 1'b0;
    end else begin
      wbin   <= wbin_nx;
      wgray  <= wgray_nx;
      full_q <= laps_apart(wgray_nx, rgray_sync);
    end

  assign waddr   = wbin[AW-1:0];
  assign wr_flag = (mode_q == MODE_FWFT) ? full_q : ~full_q;

  // R3: a write request while full leaves the write pointer alone
  a_r3_write_ignored_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && full_q) |=> $stable(wbin));

  // R10: the Gray pointer seen by the other domain moves by one bit at most
  a_r10_wgray_one_step: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ($countones(wgray ^ $past(wgray)) <= 1));
endmodule

// File: rtl/tmf_rd_ctrl.sv
module tmf_rd_ctrl
  import tmf_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mrst_n,
  input  logic          mode_pin,
  input  logic          rd_en,
  input  logic [AW:0]   wgray_sync,
  input  logic [DW-1:0] rdata,
  output logic [AW-1:0] raddr,
  output logic [AW:0]   rgray,
  output logic [DW-1:0] dout,
  output logic          rd_flag
);
  fifo_mode_e  mode_q;
  logic [AW:0] rbin, rbin_nx, rgray_nx;
  logic        ne_q;      // standard mode: array holds at least one word
  logic        ov_q;      // fall-through mode: output register holds a word
  logic        avail;     // array not empty as seen now
  logic        std_pop, fw_pop, core_pop, ov_nx;
  logic        is_fwft;

  function automatic logic [AW:0] to_gray(input logic [AW:0] b);
    return b ^ (b >> 1);
  endfunction

  always_ff @(posedge clk)
    if (!mrst_n) mode_q <= fifo_mode_e'(mode_pin);

  assign is_fwft  = (mode_q == MODE_FWFT);
  assign avail    = (rgray != wgray_sync);
  assign std_pop  = ~is_fwft & rd_en & ne_q;
  assign fw_pop   = is_fwft & avail & (~ov_q | rd_en);
  assign core_pop = std_pop | fw_pop;
  assign rbin_nx  = rbin + {{AW{1'b0}}, core_pop};
  assign rgray_nx = to_gray(rbin_nx);

  always_comb begin
    ov_nx = ov_q;
    if (!is_fwft)      ov_nx = 1'b0;
    else if (fw_pop)   ov_nx = 1'b1;
    else if (rd_en)    ov_nx = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rbin  <= '0;
      rgray <= '0;
      ne_q  <= 1'b0;
      ov_q  <= 1'b0;
      dout  <= '0;
    end else begin
      rbin  <= rbin_nx;
      rgray <= rgray_nx;
      ne_q  <= (rgray_nx != wgray_sync);
      ov_q  <= ov_nx;
      if (core_pop) dout <= rdata;
    end

  assign raddr   = rbin[AW-1:0];
  assign rd_flag = is_fwft ? ~ov_q : ne_q;

  // R3: a read request on an empty standard-mode FIFO changes nothing
  a_r3_read_ignored_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_fwft && rd_en && !ne_q) |=> ($stable(rbin) && $stable(dout)));

  // R7: without a read request the standard-mode output register holds
  a_r7_dout_holds_std: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_fwft && !rd_en) |=> $stable(dout));

  // R6: a presented word is only withdrawn by a read
  a_r6_word_kept_until_read: assert property (@(posedge clk) disable iff (!rst_n)
    (is_fwft && ov_q && !rd_en) |=> (ov_q && $stable(dout)));

  // R6: output-ready deasserts only after a read request
  a_r6_ready_drop_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
    (is_fwft && $fell(ov_q)) |-> $past(rd_en));

  // R10: read pointer Gray code moves one bit at most
  a_r10_rgray_one_step: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ($countones(rgray ^ $past(rgray)) <= 1));
endmodule

// File: rtl/twin_mode_fifo.sv
module twin_mode_fifo #(
  parameter int DW          = 9,
  parameter int DEPTH       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic          wr_clk,
  input  logic          rd_clk,
  input  logic          mrst_n,
  input  logic          prst_n,
  input  logic          fwft_sel,
  input  logic          wr_en,
  input  logic [DW-1:0] din,
  input  logic          rd_en,
  output logic [DW-1:0] dout,
  output logic          wr_flag,
  output logic          rd_flag
);
  localparam int AW = $clog2(DEPTH);

  logic          rst_n;
  logic [AW:0]   wgray, rgray, wgray_rd, rgray_wr;
  logic [AW-1:0] waddr, raddr;
  logic          push;
  logic [DW-1:0] rdata;
  logic [DW-1:0] mem [DEPTH];

  assign rst_n = mrst_n & prst_n;

  always_ff @(posedge wr_clk)
    if (push) mem[waddr] <= din;

  assign rdata = mem[raddr];

  tmf_wr_ctrl #(.AW(AW)) u_wr (
    .clk(wr_clk), .rst_n(rst_n), .mrst_n(mrst_n), .mode_pin(fwft_sel),
    .wr_en(wr_en), .rgray_sync(rgray_wr), .wgray(wgray), .waddr(waddr),
    .push(push), .wr_flag(wr_flag)
  );

  tmf_rd_ctrl #(.AW(AW), .DW(DW)) u_rd (
    .clk(rd_clk), .rst_n(rst_n), .mrst_n(mrst_n), .mode_pin(fwft_sel),
    .rd_en(rd_en), .wgray_sync(wgray_rd), .rdata(rdata), .raddr(raddr),
    .rgray(rgray), .dout(dout), .rd_flag(rd_flag)
  );

  tmf_sync #(.W(AW+1), .STAGES(SYNC_STAGES)) u_w2r (
    .clk(rd_clk), .rst_n(rst_n), .d(wgray), .q(wgray_rd)
  );

  tmf_sync #(.W(AW+1), .STAGES(SYNC_STAGES)) u_r2w (
    .clk(wr_clk), .rst_n(rst_n), .d(rgray), .q(rgray_wr)
  );
endmodule

// File: tb/twin_mode_fifo_test.sv
module twin_mode_fifo_test;
  localparam int DW = 9;
  localparam int DEPTH = 16;

  logic wr_clk = 1'b0;
  logic rd_clk = 1'b0;
  logic mrst_n = 1'b0;
  logic prst_n = 1'b1;
  logic fwft_sel = 1'b0;
  logic wr_en = 1'b0;
  logic rd_en = 1'b0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic wr_flag, rd_flag;

  int nchk = 0;
  int nerr = 0;
  bit fw = 1'b0;
  bit accepted;
  logic [DW-1:0] q[$];
  logic [DW-1:0] last_word;

  twin_mode_fifo #(.DW(DW), .DEPTH(DEPTH)) uut (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .mrst_n(mrst_n), .prst_n(prst_n),
    .fwft_sel(fwft_sel), .wr_en(wr_en), .din(din), .rd_en(rd_en),
    .dout(dout), .wr_flag(wr_flag), .rd_flag(rd_flag)
  );

  // write edges at 10+20k (even), read edges at 1+36k (odd): never coincide
  always #10 wr_clk = ~wr_clk;
  initial begin
    #1 rd_clk = 1'b1;
    forever #18 rd_clk = ~rd_clk;
  end

  initial begin
    #(200000 * 20);
    nerr++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  function automatic bit has_space();
    return fw ? (wr_flag == 1'b0) : (wr_flag == 1'b1);
  endfunction

  function automatic bit has_data();
    return fw ? (rd_flag == 1'b0) : (rd_flag == 1'b1);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic master_reset(input bit mode);
    @(negedge wr_clk);
    mrst_n = 1'b0;
    fwft_sel = mode;
    repeat (6) @(negedge wr_clk);
    mrst_n = 1'b1;
    fwft_sel = ~mode;
    fw = mode;
    q.delete();
    #1;
  endtask

  task automatic write_word(input logic [DW-1:0] d);
    @(negedge wr_clk);
    accepted = has_space();
    wr_en = 1'b1;
    din = d;
    @(posedge wr_clk);
    #1 wr_en = 1'b0;
    if (accepted) q.push_back(d);
  endtask

  task automatic read_word(input string req);
    logic [DW-1:0] exp;
    bit take;
    @(negedge rd_clk);
    take = has_data();
    exp = '0;
    if (take) begin
      exp = q.pop_front();
      if (fw) check(req, dout, exp);
    end
    rd_en = 1'b1;
    @(posedge rd_clk);
    #2 rd_en = 1'b0;
    if (take) begin
      if (!fw) check(req, dout, exp);
      last_word = exp;
    end
  endtask

  task automatic rd_wait(input int n);
    repeat (n) @(posedge rd_clk);
    #2;
  endtask

  task automatic drain(input string req);
    rd_wait(8);
    for (int i = 0; i < DEPTH + 4; i++) begin
      if (has_data()) read_word(req);
    end
    rd_wait(2);
    check(req, q.size(), 0);
    check(req, has_data(), 0);
  endtask

  task automatic random_phase(input int ops, input int wr_pct);
    for (int i = 0; i < ops; i++) begin
      if (($urandom % 100) < wr_pct) write_word(DW'($urandom));
      else read_word("R10 random order");
    end
    drain("R10 drain order");
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));

    // ---------------- standard mode ----------------
    master_reset(1'b0);
    check("R8 std full flag", wr_flag, 1);
    check("R8 std empty flag", rd_flag, 0);
    check("R8 std dout", dout, 0);

    write_word(9'h15A);
    rd_wait(8);
    check("R4 not empty", rd_flag, 1);
    check("R4 no auto present", dout, 0);
    check("R7 dout held without rd_en", dout, 0);
    read_word("R4 explicit read");
    check("R4 empty after read", rd_flag, 0);
    read_word("R3 read on empty");
    check("R3 std dout after empty read", dout, 9'h15A);
    check("R3 std still empty", rd_flag, 0);

    rd_wait(4);
    for (int i = 0; i < DEPTH - 1; i++) write_word(DW'(9'h040 + i));
    #2 check("R1 not full at DEPTH-1", wr_flag, 1);
    write_word(9'h0F0);
    check("R1 full at DEPTH", wr_flag, 0);
    write_word(9'h1FF);
    check("R3 write while full refused", accepted, 0);
    drain("R1 contents after fill");

    // ---------------- fall-through mode ----------------
    master_reset(1'b1);
    check("R8 fwft ready-in flag", wr_flag, 0);
    check("R8 fwft ready-out flag", rd_flag, 1);
    check("R8 fwft dout", dout, 0);

    @(negedge wr_clk);
    wr_en = 1'b1;
    din = 9'h0C3;
    @(posedge wr_clk);
    q.push_back(9'h0C3);
    #1 wr_en = 1'b0;
    @(posedge rd_clk); #2;
    check("R5 edge1 not ready", rd_flag, 1);
    @(posedge rd_clk); #2;
    check("R5 edge2 not ready", rd_flag, 1);
    @(posedge rd_clk); #2;
    check("R5 edge3 ready", rd_flag, 0);
    check("R5 edge3 data", dout, 9'h0C3);

    rd_wait(4);
    for (int i = 0; i < DEPTH - 1; i++) write_word(DW'(9'h100 + i));
    #2 check("R2 ready after DEPTH writes", wr_flag, 0);
    write_word(9'h0AA);
    check("R2 full after DEPTH+1 writes", wr_flag, 1);
    write_word(9'h155);
    check("R3 fwft write while full refused", accepted, 0);

    rd_wait(8);
    for (int i = 0; i < DEPTH; i++) read_word("R10 fwft fill order");
    check("R6 ready held before last read", rd_flag, 0);
    read_word("R6 last word");
    check("R6 not ready after last read", rd_flag, 1);
    check("R6 dout keeps last", dout, 9'h0AA);
    read_word("R3 fwft read on empty");
    check("R3 fwft dout after empty read", dout, 9'h0AA);
    check("R3 fwft still not ready", rd_flag, 1);

    // partial reset keeps mode
    for (int i = 0; i < 3; i++) write_word(DW'(9'h011 + i));
    rd_wait(6);
    @(negedge wr_clk);
    fwft_sel = 1'b0;
    prst_n = 1'b0;
    repeat (4) @(negedge wr_clk);
    prst_n = 1'b1;
    q.delete();
    #1;
    check("R9 ready-in after partial reset", wr_flag, 0);
    check("R9 ready-out after partial reset", rd_flag, 1);
    write_word(9'h0AB);
    rd_wait(8);
    check("R9 fall-through kept", rd_flag, 0);
    check("R9 fall-through data", dout, 9'h0AB);
    drain("R9 drain");

    random_phase(300, 65);
    random_phase(300, 35);

    master_reset(1'b0);
    check("R8 std flags again", {wr_flag, rd_flag}, 2'b10);
    random_phase(300, 65);
    random_phase(300, 35);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule